// File: doc/BRIEF.md
# Write-Leveling DQS Delay Search

This block calibrates the write strobe timing of one or more byte lanes of a DRAM interface. With board routing that daisy-chains the clock past each memory device, every device receives the clock at a different moment. Each byte lane therefore needs its own strobe delay. On a start pulse the block raises a mode request that puts the memory into its leveling mode. It then runs repeated probes. In each probe it waits a programmable settle time, pulses DQS once and samples the per-lane feedback. The feedback is the level of the memory clock that the device captured at the strobe edge.

Every lane that is still searching moves its delay tap up by one after each sample. A lane stops once its feedback has gone from low to high and stayed high for two samples in a row. It keeps the tap at which high was first seen, which places the strobe on the clock rising edge. A lane that reaches its last tap without such a change is marked failed and holds that last tap. All lanes are searched in parallel. When every lane has stopped, the block drops the mode request, waits one more settle period and raises a global done flag. The delay line itself is outside this block and is driven by the tap index outputs.

Top module: `wlvl_search`

## Requirements
- R1: After reset, `lvl_mode_en`, `dqs_pulse`, `all_done`, every `lane_done` and `lane_fail` bit are 0 and every tap field of `tap_out` is 0.
- R2: A `start` accepted while idle or done raises `lvl_mode_en` in the next cycle. The first `dqs_pulse` comes 2*(S+1) cycles after `lvl_mode_en` rises, where S is the `settle_cycles` value latched with `start`.
- R3: While searching, consecutive `dqs_pulse` cycles are exactly S+3 cycles apart.
- R4: Feedback is sampled in the cycle after each `dqs_pulse`. Every lane still searching then advances its tap by exactly one, so its tap at one pulse is one more than at the previous pulse.
- R5: A lane is accepted (`lane_done`=1) when, after at least one sample of 0, two consecutive samples read 1. Its tap field then holds the tap of the first of those two samples.
- R6: Samples of 1 taken before the lane has ever sampled 0 do not count as a transition. A lane whose feedback is 1 at every tap therefore fails.
- R7: A single sample of 1 followed by a sample of 0 is rejected. The search continues and needs a fresh 0-to-1 change.
- R8: A lane that samples at tap MAX_TAP (the largest tap code, 63 by default) without being accepted sets `lane_fail`=1 and keeps MAX_TAP in its tap field. `lane_done` and `lane_fail` are never both 1.
- R9: Once a lane has stopped, its tap field and its flag do not change until the next `start`, while the other lanes keep searching.
- R10: After the last lane stops, `lvl_mode_en` falls. `all_done` rises S+1 cycles later and stays high until the next `start`, which clears `all_done`, all lane flags and all taps in the following cycle.
- R11: `dqs_pulse` is only ever 1 while `lvl_mode_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (ignored while one is running) |
| settle_cycles | input | SETTLE_W | Settle wait S, latched with `start` |
| fb | input | LANES | Per-lane sampled clock level returned by the memory |
| lvl_mode_en | output | 1 | Request to hold the memory in leveling mode |
| dqs_pulse | output | 1 | One-cycle strobe probe request |
| tap_out | output | LANES*TAP_W | Per-lane delay tap index, lane 0 in the low bits |
| lane_done | output | LANES | Lane found its transition |
| lane_fail | output | LANES | Lane ran out of taps |
| all_done | output | 1 | Every lane has stopped and leveling mode is off |

## Verification
A lane that misreads its feedback history shows up within one probe of the feedback change. It either stops one tap early or late, or it never stops. This appears directly in the final tap field and in the done or fail flag once `all_done` rises. A broken sequencer state shows up as a wrong pulse spacing or a wrong delay from `start` to the first pulse, visible by the second pulse. A lane that keeps stepping after it has stopped shows up as a tap differing between the moment its flag rose and the end of the run. Feedback patterns with leading ones, lone glitches, late thresholds and no transition at all separate the acceptance rule from simpler threshold detection.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_MODE_ON,
      SQ_SETTLE,
      SQ_PULSE,
      SQ_SAMPLE,
      SQ_MODE_OFF,
      SQ_DONE
   } wl_seq_e;

   function automatic int cnt_width(input int max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/wlvl_wait_timer.sv
module wlvl_wait_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/wlvl_seq.sv
module wlvl_seq
   import wlvl_pkg::*;
#(
   parameter int SETTLE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [SETTLE_W-1:0] settle_in,
   input  logic                all_finished,
   output logic                lvl_mode_en,
   output logic                dqs_pulse,
   output logic                sample_en,
   output logic                lane_clear,
   output logic                all_done
);

   wl_seq_e             state_q, state_d;
   logic [SETTLE_W-1:0] settle_q;
   logic                tmr_load;
   logic [SETTLE_W-1:0] tmr_val;
   logic                tmr_expired;
   logic                start_ok;

   assign start_ok = start && (state_q == SQ_IDLE || state_q == SQ_DONE);

   wlvl_wait_timer #(.CNT_W(SETTLE_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = settle_q;
      unique case (state_q)
         SQ_IDLE, SQ_DONE: begin
            if (start) begin
               state_d  = SQ_MODE_ON;
               tmr_load = 1'b1;
               tmr_val  = settle_in;
            end
         end
         SQ_MODE_ON: begin
            if (tmr_expired) begin
               state_d  = SQ_SETTLE;
               tmr_load = 1'b1;
            end
         end
         SQ_SETTLE: begin
            if (all_finished) begin
               state_d  = SQ_MODE_OFF;
               tmr_load = 1'b1;
            end else if (tmr_expired) begin
               state_d = SQ_PULSE;
            end
         end
         SQ_PULSE:  state_d = SQ_SAMPLE;
         SQ_SAMPLE: begin
            state_d  = SQ_SETTLE;
            tmr_load = 1'b1;
         end
         SQ_MODE_OFF: begin
            if (tmr_expired) state_d = SQ_DONE;
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         settle_q <= '0;
      end else begin
         state_q <= state_d;
         if (start_ok) settle_q <= settle_in;
      end
   end

   assign lvl_mode_en = (state_q == SQ_MODE_ON) || (state_q == SQ_SETTLE) ||
                        (state_q == SQ_PULSE)   || (state_q == SQ_SAMPLE);
   assign dqs_pulse   = (state_q == SQ_PULSE);
   assign sample_en   = (state_q == SQ_SAMPLE);
   assign lane_clear  = start_ok;
   assign all_done    = (state_q == SQ_DONE);

   // R11: strobe probes only inside leveling mode
   assert_pulse_in_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
      dqs_pulse |-> lvl_mode_en);

   // R4: feedback is sampled the cycle after a probe
   assert_sample_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dqs_pulse |=> sample_en);

   // R10: done holds until a new start
   assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (all_done && !start) |=> all_done);

endmodule

// File: rtl/wlvl_lane.sv
module wlvl_lane
   import wlvl_pkg::*;
#(
   parameter int TAP_W   = 6,
   parameter int MAX_TAP = 63,
   parameter int CONFIRM = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sample_en,
   input  logic             fb,
   output logic [TAP_W-1:0] tap,
   output logic             done,
   output logic             fail,
   output logic             finished
);

   localparam int               CONF_W   = cnt_width(CONFIRM);
   localparam logic [TAP_W-1:0] TAP_LAST = TAP_W'(MAX_TAP);

   logic [TAP_W-1:0]  cand_q;
   logic [CONF_W-1:0] ones_q;
   logic              saw_zero_q;
   logic              at_last;
   logic              confirm_hit;

   assign finished    = done || fail;
   assign at_last     = (tap == TAP_LAST);
   assign confirm_hit = (int'(ones_q) + 1 >= CONFIRM);

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         tap        <= '0;
         cand_q     <= '0;
         ones_q     <= '0;
         saw_zero_q <= 1'b0;
         done       <= 1'b0;
         fail       <= 1'b0;
      end else if (sample_en && !finished) begin
         if (fb && saw_zero_q && confirm_hit) begin
            done <= 1'b1;
            if (ones_q != '0) tap <= cand_q;
         end else begin
            if (fb && saw_zero_q) begin
               if (ones_q == '0) cand_q <= tap;
               ones_q <= ones_q + 1'b1;
            end else if (!fb) begin
               saw_zero_q <= 1'b1;
               ones_q     <= '0;
            end
            if (at_last) fail <= 1'b1;
            else         tap  <= tap + 1'b1;
         end
      end
   end

   // R8: tap never passes the last code
   assert_tap_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tap <= TAP_LAST);

   // R8: success and failure exclusive
   assert_flag_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   // R9: a stopped lane holds tap and flag
   assert_finished_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (finished && !clear) |=> ($stable(tap) && finished));

   // R5: acceptance only on a sample that read 1
   assert_accept_on_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(sample_en && fb));

endmodule

// File: rtl/wlvl_search.sv
module wlvl_search
   import wlvl_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int TAP_W    = 6,
   parameter int MAX_TAP  = 63,
   parameter int SETTLE_W = 8,
   parameter int CONFIRM  = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [SETTLE_W-1:0]    settle_cycles,
   input  logic [LANES-1:0]       fb,
   output logic                   lvl_mode_en,
   output logic                   dqs_pulse,
   output logic [LANES*TAP_W-1:0] tap_out,
   output logic [LANES-1:0]       lane_done,
   output logic [LANES-1:0]       lane_fail,
   output logic                   all_done
);

   if (LANES < 1) begin : g_bad_lanes
      $error("wlvl_search: LANES must be at least 1");
   end
   if (MAX_TAP < 1 || MAX_TAP > (2**TAP_W) - 1) begin : g_bad_max_tap
      $error("wlvl_search: MAX_TAP must fit in TAP_W bits");
   end
   if (CONFIRM < 1) begin : g_bad_confirm
      $error("wlvl_search: CONFIRM must be at least 1");
   end
   if (SETTLE_W < 1) begin : g_bad_settle
      $error("wlvl_search: SETTLE_W must be at least 1");
   end

   logic             sample_en;
   logic             lane_clear;
   logic [LANES-1:0] finished;

   wlvl_seq #(.SETTLE_W(SETTLE_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .settle_in    (settle_cycles),
      .all_finished (&finished),
      .lvl_mode_en  (lvl_mode_en),
      .dqs_pulse    (dqs_pulse),
      .sample_en    (sample_en),
      .lane_clear   (lane_clear),
      .all_done     (all_done)
   );

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      wlvl_lane #(
         .TAP_W   (TAP_W),
         .MAX_TAP (MAX_TAP),
         .CONFIRM (CONFIRM)
      ) u_lane (
         .clk       (clk),
         .rst_n     (rst_n),
         .clear     (lane_clear),
         .sample_en (sample_en),
         .fb        (fb[l]),
         .tap       (tap_out[l*TAP_W +: TAP_W]),
         .done      (lane_done[l]),
         .fail      (lane_fail[l]),
         .finished  (finished[l])
      );
   end

   // R10: global done only when every lane has stopped
   assert_all_done_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
      all_done |-> (&finished));

   // R10: leveling mode is off once done
   assert_done_mode_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      all_done |-> !lvl_mode_en);

endmodule

// File: tb/wlvl_search_bench.sv
module wlvl_search_bench;

   localparam int LANES = 4;
   localparam int TAP_W = 6;
   localparam int MAXT  = 63;

   typedef struct {
      int    lane;
      bit    done;
      bit    fail;
      int    tap;
      string tag;
   } exp_item_t;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic                   start = 1'b0;
   logic [7:0]             settle_cycles = '0;
   logic [LANES-1:0]       fb;
   logic                   lvl_mode_en;
   logic                   dqs_pulse;
   logic [LANES*TAP_W-1:0] tap_out;
   logic [LANES-1:0]       lane_done;
   logic [LANES-1:0]       lane_fail;
   logic                   all_done;

   logic [63:0] pat [LANES];
   string       ltag [LANES];
   exp_item_t   exp_q [$];

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int cur_s  = 0;
   int bad_pulse = 0;
   bit result_seen = 0;
   bit ended = 0;

   // monitor state, cleared by the driver before each run
   int n_pulse, t_mode, t_off, t_pulse;
   int tap1 [LANES];
   int held [LANES];
   bit prev_mode, prev_all;
   bit prev_fin [LANES];

   always #5 clk = ~clk;

   wlvl_search #(
      .LANES(LANES), .TAP_W(TAP_W), .MAX_TAP(MAXT), .SETTLE_W(8), .CONFIRM(2)
   ) u_wlvl_search (
      .clk(clk), .rst_n(rst_n), .start(start), .settle_cycles(settle_cycles),
      .fb(fb), .lvl_mode_en(lvl_mode_en), .dqs_pulse(dqs_pulse),
      .tap_out(tap_out), .lane_done(lane_done), .lane_fail(lane_fail),
      .all_done(all_done)
   );

   // memory feedback model: level seen at the current tap of each lane
   always_comb begin
      for (int l = 0; l < LANES; l++) fb[l] = pat[l][tap_out[l*TAP_W +: TAP_W]];
   end

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int tap_of(input int l);
      return int'(tap_out[l*TAP_W +: TAP_W]);
   endfunction

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   function automatic logic [63:0] ramp(input int thr);
      logic [63:0] v = '0;
      for (int t = 0; t < 64; t++) if (t >= thr) v[t] = 1'b1;
      return v;
   endfunction

   // reference of the acceptance rule, stepping tap by tap
   task automatic model(input logic [63:0] p, output bit d, output bit f, output int t);
      bit saw0 = 0;
      int ones = 0;
      int cand = 0;
      d = 0; f = 1; t = MAXT;
      for (int k = 0; k <= MAXT; k++) begin
         if (p[k] && saw0) begin
            ones++;
            if (ones == 1) cand = k;
            if (ones >= 2) begin
               d = 1; f = 0; t = cand;
               return;
            end
         end else if (!p[k]) begin
            saw0 = 1;
            ones = 0;
         end
      end
   endtask

   // monitor: timing checks and scoreboard comparison
   always @(negedge clk) begin
      if (rst_n) begin
         if (dqs_pulse && !lvl_mode_en) bad_pulse++;
         if (lvl_mode_en && !prev_mode) t_mode = cyc;
         if (!lvl_mode_en && prev_mode) t_off = cyc;
         if (dqs_pulse) begin
            n_pulse++;
            if (n_pulse == 1) begin
               check(cyc - t_mode == 2*(cur_s+1), "R2 first pulse delay", cyc - t_mode, 2*(cur_s+1));
               for (int l = 0; l < LANES; l++) tap1[l] = tap_of(l);
            end else if (n_pulse == 2) begin
               check(cyc - t_pulse == cur_s + 3, "R3 pulse spacing", cyc - t_pulse, cur_s + 3);
               for (int l = 0; l < LANES; l++)
                  check(tap_of(l) == tap1[l] + 1, "R4 tap step", tap_of(l), tap1[l] + 1);
            end
            t_pulse = cyc;
         end
         for (int l = 0; l < LANES; l++) begin
            if ((lane_done[l] || lane_fail[l]) && !prev_fin[l]) held[l] = tap_of(l);
            prev_fin[l] = lane_done[l] || lane_fail[l];
         end
         if (all_done && !prev_all) begin
            check(cyc - t_off == cur_s + 1, "R10 done after mode off", cyc - t_off, cur_s + 1);
            for (int k = 0; k < LANES; k++) begin
               exp_item_t it;
               if (exp_q.size() == 0) begin
                  check(0, "scoreboard empty", 0, 1);
                  break;
               end
               it = exp_q.pop_front();
               check(lane_done[it.lane] == it.done, {it.tag, " done flag"}, int'(lane_done[it.lane]), int'(it.done));
               check(lane_fail[it.lane] == it.fail, {it.tag, " fail flag"}, int'(lane_fail[it.lane]), int'(it.fail));
               check(tap_of(it.lane) == it.tap, {it.tag, " tap"}, tap_of(it.lane), it.tap);
               check(tap_of(it.lane) == held[it.lane], "R9 tap held after stop", tap_of(it.lane), held[it.lane]);
            end
            result_seen = 1;
         end
         prev_mode = lvl_mode_en;
         prev_all  = all_done;
      end
   end

   task automatic run_case(input int s);
      bit d, f;
      int t;
      @(negedge clk);
      cur_s = s;
      n_pulse = 0;
      for (int l = 0; l < LANES; l++) begin
         model(pat[l], d, f, t);
         exp_q.push_back('{l, d, f, t, ltag[l]});
      end
      start = 1'b1;
      settle_cycles = 8'(s);
      @(negedge clk);
      start = 1'b0;
      check(all_done == 1'b0, "R10 start clears done", int'(all_done), 0);
      check(lane_done == '0 && lane_fail == '0, "R10 start clears flags",
            int'(lane_done | lane_fail), 0);
      check(tap_out == '0, "R10 start clears taps", int'(tap_out), 0);
      check(lvl_mode_en == 1'b1, "R2 mode on after start", int'(lvl_mode_en), 1);
      while (!result_seen) @(negedge clk);
      result_seen = 0;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      if (!ended) begin
         ended = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      for (int l = 0; l < LANES; l++) begin
         pat[l] = '0;
         ltag[l] = "R5";
         prev_fin[l] = 0;
      end
      prev_mode = 0; prev_all = 0;
      repeat (3) @(negedge clk);
      check(!lvl_mode_en && !dqs_pulse && !all_done, "R1 reset controls",
            int'({lvl_mode_en, dqs_pulse, all_done}), 0);
      check(lane_done == '0 && lane_fail == '0, "R1 reset flags", int'(lane_done | lane_fail), 0);
      check(tap_out == '0, "R1 reset taps", int'(tap_out), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!lvl_mode_en, "R1 idle without start", int'(lvl_mode_en), 0);

      // plain thresholds, leading ones, lone glitch
      pat[0] = ramp(10);                         ltag[0] = "R5";
      pat[1] = ramp(3);                          ltag[1] = "R5";
      pat[2] = ramp(20) | 64'h1F;                ltag[2] = "R6";
      pat[3] = ramp(15) | (64'h1 << 7);          ltag[3] = "R7";
      run_case(2);

      // no transition, all ones, last-tap single one, late threshold
      pat[0] = '0;                               ltag[0] = "R8";
      pat[1] = '1;                               ltag[1] = "R6";
      pat[2] = ramp(63);                         ltag[2] = "R8";
      pat[3] = ramp(62);                         ltag[3] = "R5";
      run_case(0);

      // early thresholds and a double glitch, longer settle
      pat[0] = ramp(1);                          ltag[0] = "R5";
      pat[1] = ramp(40) | (64'h1 << 30) | (64'h1 << 33); ltag[1] = "R7";
      pat[2] = ramp(2);                          ltag[2] = "R5";
      pat[3] = ramp(33);                         ltag[3] = "R9";
      run_case(5);

      check(bad_pulse == 0, "R11 pulse outside mode", bad_pulse, 0);
      summary();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

endmodule